// File: doc/BRIEF.md
# Masked Interrupt Priority Selector

This block picks which of six pending interrupt sources is delivered next. Its inputs are a vector of level-sensitive pending flags and the external-enable bit of the machine state. Its output is a one-hot code naming the single winning source, together with a valid flag. When nothing deliverable is pending, both are zero. The code is computed combinationally and captured in a register on each clock edge, so an exception entry controller downstream sees a stable choice for a full cycle.

The sources are split into two classes. The critical class (reset request and machine check) is always deliverable. The asynchronous class (watchdog, external input, fixed-interval timer and decrementer) competes only while the external-enable bit is set. Within each class a fixed order applies, and any critical source beats any asynchronous one.

The selector keeps no state other than its output register. The flags stay asserted until they are acknowledged somewhere else, and the block neither clears nor acknowledges them. The selection is a single pass with no sequencing: the combinational path filters the requests through the enable mask, then a priority chain picks one, and the registered stage holds the result.

Top module: `irqsel_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the edge clears `grant_o` to 0 and `valid_o` to 0.
- R2: Pending bit 0 (reset request) is granted as `grant_o = 6'b000001` whatever the other flags and the enable bit are.
- R3: Pending bit 1 (machine check) is granted as `grant_o = 6'b000010` when bit 0 is clear, whether `ext_en_i` is 0 or 1.
- R4: When `ext_en_i` is 0, pending bits 2 to 5 are ignored: with bits 0 and 1 clear, `grant_o` is 0 and `valid_o` is 0.
- R5: When `ext_en_i` is 1 and bits 0 and 1 are clear, the asynchronous order from highest to lowest is bit 2 (watchdog), bit 3 (external input), bit 4 (fixed-interval timer), bit 5 (decrementer). The lowest-numbered set bit is granted as a one-hot code at that bit position.
- R6: With no pending bit set, `grant_o` is 0 and `valid_o` is 0.
- R7: The output follows the inputs with exactly one cycle of latency. The values present at a rising edge appear on the outputs after that edge, and the outputs do not change between edges.
- R8: `grant_o` has at most one bit set, and `valid_o` is 1 exactly when `grant_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 6 | Pending flags: bit 0 reset, 1 machine check, 2 watchdog, 3 external, 4 fixed-interval, 5 decrementer |
| ext_en_i | input | 1 | External-enable bit of the machine state |
| grant_o | output | 6 | Registered one-hot code of the winning source |
| valid_o | output | 1 | Registered flag that a source was granted |

## Verification
Enable masking and priority resolution act in the same cycle. A critical flag and several asynchronous flags are raised together with the enable bit both high and low. Each pattern is judged by whether the mask removed the asynchronous class before the priority chain ran. For example, the machine check must win over a pending watchdog when the enable is low, and the watchdog must win over the external input when the enable is high. Each registered result is compared, one cycle later, against a priority model written in the bench.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int NSRC     = 6;
    localparam int N_ALWAYS = 2;

    typedef enum logic [2:0] {
        SRC_RESET  = 3'd0,
        SRC_MCHECK = 3'd1,
        SRC_WDOG   = 3'd2,
        SRC_EXTIN  = 3'd3,
        SRC_FIXINT = 3'd4,
        SRC_DECR   = 3'd5
    } src_e;
endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate #(
    parameter int N        = 6,
    parameter int N_ALWAYS = 2
) (
    input  logic [N-1:0] req_i,
    input  logic         en_i,
    output logic [N-1:0] req_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i < N_ALWAYS) begin : g_crit
            assign req_o[i] = req_i[i];
        end else begin : g_async
            assign req_o[i] = req_i[i] & en_i;
        end
    end
endmodule

// File: rtl/irqsel_prio.sv
module irqsel_prio #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] sel_o
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign sel_o[i]       = req_i[i] & ~blocked[i];
        assign blocked[i + 1] = blocked[i] | req_i[i];
    end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int N        = NSRC,
    parameter int N_CRIT   = N_ALWAYS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend_i,
    input  logic         ext_en_i,
    output logic [N-1:0] grant_o,
    output logic         valid_o
);
    logic [N-1:0] masked;
    logic [N-1:0] pick;
    logic [N-1:0] grant_q;
    logic         valid_q;

    irqsel_gate #(.N(N), .N_ALWAYS(N_CRIT)) gate_i (
        .req_i (pend_i),
        .en_i  (ext_en_i),
        .req_o (masked)
    );

    irqsel_prio #(.N(N)) prio_i (
        .req_i (masked),
        .sel_o (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            valid_q <= 1'b0;
        end else begin
            grant_q <= pick;
            valid_q <= |masked;
        end
    end

    assign grant_o = grant_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] pend_i,
    input logic       ext_en_i,
    input logic [5:0] grant_o,
    input logic       valid_o
);
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    a_r8_valid_match: assert property (@(posedge clk) disable iff (rst)
        valid_o == (grant_o != 6'd0));

    a_r2_reset_wins: assert property (@(posedge clk) disable iff (rst)
        pend_i[0] |=> grant_o == 6'b000001);

    a_r3_mcheck_wins: assert property (@(posedge clk) disable iff (rst)
        (pend_i[1:0] == 2'b10) |=> grant_o == 6'b000010);

    a_r4_async_masked: assert property (@(posedge clk) disable iff (rst)
        (!ext_en_i && pend_i[1:0] == 2'b00) |=> !valid_o);

    a_r5_wdog_first: assert property (@(posedge clk) disable iff (rst)
        (ext_en_i && pend_i[2:0] == 3'b100) |=> grant_o == 6'b000100);

    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        (pend_i == 6'd0) |=> !valid_o);
endmodule

bind irqsel_top irqsel_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend_i),
    .ext_en_i (ext_en_i),
    .grant_o  (grant_o),
    .valid_o  (valid_o)
);

// File: tb/irqsel_top_tb.sv
`timescale 1ns/1ps
module irqsel_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] pend_i = '0;
    logic       ext_en_i = 1'b0;
    logic [5:0] grant_o;
    logic       valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irqsel_top dut_i (
        .clk(clk), .rst(rst), .pend_i(pend_i), .ext_en_i(ext_en_i),
        .grant_o(grant_o), .valid_o(valid_o)
    );

    function automatic logic [6:0] model(input logic [5:0] p, input logic en);
        for (int i = 0; i < 6; i++) begin
            if (p[i] && (i < 2 || en)) return {1'b1, 6'(1 << i)};
        end
        return 7'd0;
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid/grant %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [5:0] p, input logic en);
        @(negedge clk);
        pend_i = p; ext_en_i = en;
        @(negedge clk);
        check(req, {valid_o, grant_o}, model(p, en));
    endtask

    task automatic t_reset;
        pend_i = 6'b111111; ext_en_i = 1'b1; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1", {valid_o, grant_o}, 7'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {valid_o, grant_o}, 7'b1000001);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", {valid_o, grant_o}, 7'd0);
        rst = 1'b0;
    endtask

    task automatic t_idle;
        apply("R6", 6'd0, 1'b1);
        apply("R6", 6'd0, 1'b0);
    endtask

    task automatic t_reset_wins;
        apply("R2", 6'b111111, 1'b0);
        apply("R2", 6'b111111, 1'b1);
        apply("R2", 6'b000001, 1'b0);
        check("R2", {valid_o, grant_o}, 7'b1000001);
    endtask

    task automatic t_mcheck;
        apply("R3", 6'b111110, 1'b0);
        check("R3", {valid_o, grant_o}, 7'b1000010);
        apply("R3", 6'b111110, 1'b1);
        check("R3", {valid_o, grant_o}, 7'b1000010);
    endtask

    task automatic t_masked;
        apply("R4", 6'b111100, 1'b0);
        check("R4", {valid_o, grant_o}, 7'd0);
        apply("R4", 6'b100000, 1'b0);
        apply("R4", 6'b001000, 1'b0);
    endtask

    task automatic t_order;
        apply("R5", 6'b111100, 1'b1);
        check("R5", {valid_o, grant_o}, 7'b1000100);
        apply("R5", 6'b111000, 1'b1);
        check("R5", {valid_o, grant_o}, 7'b1001000);
        apply("R5", 6'b110000, 1'b1);
        check("R5", {valid_o, grant_o}, 7'b1010000);
        apply("R5", 6'b100000, 1'b1);
        check("R5", {valid_o, grant_o}, 7'b1100000);
        apply("R5", 6'b101000, 1'b1);
    endtask

    task automatic t_latency;
        apply("R7", 6'b000100, 1'b1);
        @(negedge clk);
        pend_i = 6'b000010; ext_en_i = 1'b0;
        #1;
        check("R7", {valid_o, grant_o}, 7'b1000100);
        @(posedge clk); #1;
        check("R7", {valid_o, grant_o}, 7'b1000010);
    endtask

    task automatic t_sweep;
        for (int v = 0; v < 128; v++) begin
            apply("R8", v[5:0], v[6]);
            n_chk++;
            if ((valid_o !== (grant_o != 0)) || ($countones(grant_o) > 1)) begin
                n_bad++;
                $display("FAIL R8: got valid %b grant %b expected one-hot with matching valid",
                         valid_o, grant_o);
            end
        end
    endtask

    initial begin
        t_reset;
        t_idle;
        t_reset_wins;
        t_mcheck;
        t_masked;
        t_order;
        t_latency;
        t_sweep;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule